// File: doc/BRIEF.md
# Windowed Watchdog Reset Generator

This block supervises a host processor and drives its active-low reset. Once the supply is reported good, the block keeps the reset asserted for a power-on interval. It then releases the reset and waits for the host's first service pulse within a lead time. After that first pulse it runs a fixed cycle. A closed window comes first, and any service pulse inside it is a fault. An open window follows, and a service pulse inside it is accepted and starts a new closed window. A missed open window or an early pulse produces a watchdog reset pulse of fixed length. After that pulse the block returns to the lead phase.

The host services the watchdog with a falling edge on an active-low trigger input. A build option also accepts a rising edge on a second, active-high trigger input. Both inputs are synchronised with two flops. A pulse is accepted only after it has stayed asserted for a minimum number of clocks, so shorter glitches are ignored. The supply-good input is sampled directly on the clock.

All phase lengths are tick counts. One tick is a fixed number of clocks from a prescaler, so simulation can use short intervals. A mode input turns supervision off for low-power modes. While it is high, the reset output stays released and no watchdog pulse is issued.

Top module: `wdog_window`

## Requirements
- R1: While `rst_n` is low or `supply_ok` is low, `rst_out_n` is 0. After `supply_ok` rises, `rst_out_n` stays 0 for exactly T_POR ticks and then goes to 1.
- R2: If no accepted trigger arrives within T_LEAD ticks after the reset is released, `rst_out_n` goes to 0.
- R3: An accepted trigger during the T_CLOSED-tick closed window that follows an accepted trigger is a fault, and it starts a watchdog reset pulse at once.
- R4: An accepted trigger during the lead phase or the T_OPEN-tick open window keeps `rst_out_n` at 1 and starts a new closed window.
- R5: If the open window ends with no trigger, `rst_out_n` is 0 for exactly T_PULSE ticks.
- R6: When a watchdog reset pulse ends, the block re-enters the lead phase. A full T_LEAD interval then applies before the next timeout.
- R7: A falling edge on `trig_n` is a trigger. When POS_EN is 1, a rising edge on `trig_p` is also a trigger.
- R8: A trigger level held for fewer than MIN_W clocks has no effect. A level held for exactly MIN_W clocks is accepted.
- R9: While `wd_off` is 1 (and supply is good, outside the power-on interval), `rst_out_n` stays 1. When `wd_off` returns to 0, a fresh T_LEAD interval starts.
- R10: One tick is PRESC clocks, and the prescaler restarts on every phase change. Each phase therefore lasts exactly its tick count times PRESC clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the internal oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, 1 when supply is within range |
| trig_n | input | 1 | Active-low trigger; falling edge services the watchdog |
| trig_p | input | 1 | Active-high trigger, used when POS_EN is 1 |
| wd_off | input | 1 | 1 in silent/sleep modes; disables supervision |
| rst_out_n | output | 1 | Active-low reset to the host |

## Verification
The assertions assume that `supply_ok` and `wd_off` are already synchronous to `clk`. They also assume that a trigger acts on the phase only through the qualified event, which comes MIN_W plus two clocks after the pin changes. The stimulus drives every input at the falling clock edge. Trigger pulses are always separated by at least six clocks, so each pulse is qualified on its own. Random trigger gaps are drawn at least three clocks away from each window boundary, so the expected fault-or-accept outcome is never ambiguous.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int PRESC    = 4,
  parameter int T_POR    = 5,
  parameter int T_LEAD   = 12,
  parameter int T_CLOSED = 6,
  parameter int T_OPEN   = 8,
  parameter int T_PULSE  = 3,
  parameter int MIN_W    = 3,
  parameter bit POS_EN   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic trig_n,
  input  logic trig_p,
  input  logic wd_off,
  output logic rst_out_n
);

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TMAX = mx(mx(mx(T_POR, T_LEAD), mx(T_CLOSED, T_OPEN)), T_PULSE);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(PRESC + 1);
  localparam int WW   = $clog2(MIN_W + 1);

  typedef enum logic [2:0] {S_POR, S_LEAD, S_CLOSED, S_OPEN, S_PULSE} st_t;

  st_t           st, st_nx;
  logic [1:0]    sn, sp;
  logic [WW-1:0] wn, wp;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt, len;
  logic          tick, expire, ev_n, ev_p, trig_ev, restart;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sn <= 2'b11;
      sp <= 2'b00;
      wn <= '0;
      wp <= '0;
    end else begin
      sn <= {sn[0], trig_n};
      sp <= {sp[0], trig_p};
      if (sn[1]) wn <= '0;
      else if (wn != WW'(MIN_W)) wn <= wn + WW'(1);
      if (!sp[1]) wp <= '0;
      else if (wp != WW'(MIN_W)) wp <= wp + WW'(1);
    end

  assign ev_n    = !sn[1] && (wn == WW'(MIN_W - 1));
  assign ev_p    = sp[1] && (wp == WW'(MIN_W - 1));
  assign trig_ev = ev_n || (POS_EN && ev_p);

  always_comb
    case (st)
      S_POR:    len = CW'(T_POR);
      S_LEAD:   len = CW'(T_LEAD);
      S_CLOSED: len = CW'(T_CLOSED);
      S_OPEN:   len = CW'(T_OPEN);
      default:  len = CW'(T_PULSE);
    endcase

  assign tick   = (pre == PW'(PRESC - 1));
  assign expire = tick && (cnt == len - CW'(1));

  always_comb begin
    st_nx = st;
    if (!supply_ok) st_nx = S_POR;
    else if (wd_off && st != S_POR) st_nx = S_LEAD;
    else
      case (st)
        S_POR:    if (expire) st_nx = S_LEAD;
        S_LEAD:   if (trig_ev) st_nx = S_CLOSED; else if (expire) st_nx = S_PULSE;
        S_CLOSED: if (trig_ev) st_nx = S_PULSE;  else if (expire) st_nx = S_OPEN;
        S_OPEN:   if (trig_ev) st_nx = S_CLOSED; else if (expire) st_nx = S_PULSE;
        S_PULSE:  if (expire) st_nx = S_LEAD;
        default:  st_nx = S_POR;
      endcase
  end

  assign restart = (st_nx != st) || !supply_ok || (wd_off && st != S_POR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_POR;
      pre <= '0;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (restart) begin
        pre <= '0;
        cnt <= '0;
      end else if (tick) begin
        pre <= '0;
        cnt <= cnt + CW'(1);
      end else begin
        pre <= pre + PW'(1);
      end
    end

  assign rst_out_n = !(st == S_POR || st == S_PULSE);

  p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !rst_out_n);
  p_lead_timeout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LEAD && expire && !trig_ev && supply_ok && !wd_off) |=> !rst_out_n);
  p_closed_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLOSED && trig_ev && supply_ok && !wd_off) |=> (st == S_PULSE && !rst_out_n));
  p_open_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && trig_ev && supply_ok && !wd_off) |=> (st == S_CLOSED && rst_out_n));
  p_pulse_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PULSE && expire && supply_ok && !wd_off) |=> st == S_LEAD);
  p_off_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_off && supply_ok && st != S_POR) |=> rst_out_n);
  p_count_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);

endmodule

// File: tb/wdog_window_tb.sv
module wdog_window_tb;
  localparam int PRESC = 2, T_POR = 4, T_LEAD = 20, T_CLOSED = 10, T_OPEN = 10, T_PULSE = 5, MIN_W = 3;
  localparam int POR_CLK = T_POR * PRESC, LEAD_CLK = T_LEAD * PRESC, CL_CLK = T_CLOSED * PRESC;
  localparam int OP_CLK = T_OPEN * PRESC, PU_CLK = T_PULSE * PRESC, LAT = MIN_W + 2;

  logic clk = 0, rst_n, supply_ok, trig_n, trig_p, wd_off, rst_out_n;
  int checks = 0, fails = 0, cyc = 0;
  int hi_cnt = 0, lo_cnt = 0, last_hi = 0, last_lo = 0;

  always #5 clk = ~clk;

  wdog_window #(.PRESC(PRESC), .T_POR(T_POR), .T_LEAD(T_LEAD), .T_CLOSED(T_CLOSED),
    .T_OPEN(T_OPEN), .T_PULSE(T_PULSE), .MIN_W(MIN_W), .POS_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .trig_n(trig_n), .trig_p(trig_p),
    .wd_off(wd_off), .rst_out_n(rst_out_n));

  always @(negedge clk)
    if (rst_out_n) begin
      hi_cnt <= hi_cnt + 1;
      if (lo_cnt != 0) last_lo <= lo_cnt;
      lo_cnt <= 0;
    end else begin
      lo_cnt <= lo_cnt + 1;
      if (hi_cnt != 0) last_hi <= hi_cnt;
      hi_cnt <= 0;
    end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog R1..: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  function automatic bit exp_fault(int gap);
    return (gap < CL_CLK) || (gap >= CL_CLK + OP_CLK);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_low;
    while (rst_out_n) @(negedge clk);
  endtask

  task automatic wait_high;
    while (!rst_out_n) @(negedge clk);
  endtask

  task automatic fresh;
    wait_low;
    wait_high;
  endtask

  task automatic trig(bit pos, int w);
    if (pos) trig_p = 1'b1; else trig_n = 1'b0;
    step(w);
    trig_p = 1'b0;
    trig_n = 1'b1;
  endtask

  task automatic count_to_high(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rst_out_n);
  endtask

  initial begin
    int n, gap;
    bit pin, f;
    void'($urandom(32'd5150));
    rst_n = 0; supply_ok = 0; trig_n = 1; trig_p = 0; wd_off = 0;
    step(3);
    chk(rst_out_n == 0, "R1 reset state", rst_out_n, 0);
    rst_n = 1;
    step(5);
    chk(rst_out_n == 0, "R1 supply low", rst_out_n, 0);
    supply_ok = 1;
    count_to_high(n);
    chk(n == POR_CLK, "R1 R10 power-on length", n, POR_CLK);

    wait_low; wait_high; step(2);
    chk(last_hi == LEAD_CLK, "R2 lead timeout", last_hi, LEAD_CLK);
    chk(last_lo == PU_CLK, "R5 R10 pulse length", last_lo, PU_CLK);
    wait_low; wait_high; step(2);
    chk(last_hi == LEAD_CLK, "R6 lead after pulse", last_hi, LEAD_CLK);

    fresh; step(5); trig(0, MIN_W); wait_low; step(2);
    chk(last_hi == 10 + CL_CLK + OP_CLK, "R5 open window expiry", last_hi, 10 + CL_CLK + OP_CLK);

    fresh; step(5); trig(1, MIN_W); wait_low; step(2);
    chk(last_hi == 10 + CL_CLK + OP_CLK, "R7 rising trigger", last_hi, 10 + CL_CLK + OP_CLK);

    fresh; step(5); trig(0, MIN_W); step(7); trig(0, MIN_W - 1); step(13); trig(1, MIN_W - 1);
    wait_low; step(2);
    chk(last_hi == 10 + CL_CLK + OP_CLK, "R8 short pulses ignored", last_hi, 10 + CL_CLK + OP_CLK);

    fresh; step(5); trig(0, MIN_W); step(7); trig(0, MIN_W); step(3);
    chk(rst_out_n == 0, "R3 R8 closed window fault", rst_out_n, 0);
    chk(last_hi == 15 + LAT, "R3 fault timing", last_hi, 15 + LAT);

    fresh; step(4); supply_ok = 0; step(1);
    chk(rst_out_n == 0, "R1 supply drop", rst_out_n, 0);
    step(10); supply_ok = 1;
    count_to_high(n);
    chk(n == POR_CLK, "R1 power-on after drop", n, POR_CLK);

    step(3); wd_off = 1;
    n = 0;
    for (int i = 0; i < 200; i++) begin step(1); if (!rst_out_n) n++; end
    chk(n == 0, "R9 no pulse while off", n, 0);
    wd_off = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (rst_out_n);
    chk(n == LEAD_CLK, "R9 lead restart", n, LEAD_CLK);

    fresh;
    f = 1;
    for (int it = 0; it < 60; it++) begin
      pin = 1'($urandom_range(0, 1));
      if (f) begin
        step($urandom_range(2, LEAD_CLK - LAT - 4));
        trig(pin, MIN_W); step(6 - MIN_W);
        chk(rst_out_n == 1, "R4 lead accept", rst_out_n, 1);
        f = 0;
      end else begin
        if ($urandom_range(0, 3) == 0) gap = $urandom_range(6, CL_CLK - 3);
        else gap = $urandom_range(CL_CLK + 3, CL_CLK + OP_CLK - 3);
        step(gap - 6);
        trig(pin, MIN_W); step(6 - MIN_W);
        if (exp_fault(gap)) begin
          chk(rst_out_n == 0, "R3 random early trigger", rst_out_n, 0);
          wait_high;
          f = 1;
        end else begin
          chk(rst_out_n == 1, "R4 random open trigger", rst_out_n, 1);
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule